// File: doc/BRIEF.md
# Channel-Selectable IQ Sample Unpacker

The block turns a stream of 128-bit payload words into transmit sample beats. Each payload word holds four 32-bit sample pairs. Each pair carries a 16-bit I sample in its low half and a 16-bit Q sample in its high half. The payload is packed, so it holds samples only for the channels set in the channel-enable bitmap. The block spreads those samples over one or more output beats and places every channel in its own fixed output lane. A build parameter selects one of two modes. Two-channel mode (channels A and B) gives a 64-bit output. Four-channel mode (channels A to D) gives a 128-bit output.

Both sides use a valid/ready handshake. The output beat is formed combinationally from the word currently offered at the input. A small beat counter records which slice of that word is on the output. Back-pressure works as follows. While `out_ready` is low, the current beat is held and nothing is consumed. The input word is consumed only when its last output beat is accepted, and `in_ready` goes high in that cycle alone. The source must hold `in_data` and `chan_en` steady while a word is in progress.

Top module: `iq_lane_unpacker`

## Requirements
- R1: The output width is 64 bits in two-channel mode and 128 bits in four-channel mode. Channel c (A=0, B=1, C=2, D=3) occupies output bits [32c+31:32c], with I in the low 16 bits and Q in the high 16 bits.
- R2: Input pair p sits at bits [32p+31:32p]. With k channels enabled (chan_en bit c enables channel c), output beat b gives the j-th enabled channel, counted from the lowest letter, the input pair p = b*k + j.
- R3: The output lane of every disabled channel is zero whenever out_valid is high.
- R4: With exactly one channel enabled, each input word yields four output beats, carrying pairs 0, 1, 2 and 3 in that order.
- R5: With exactly two channels enabled, each input word yields two output beats.
- R6: With all four channels enabled in four-channel mode, each input word yields one output beat.
- R7: With three channels enabled, each input word yields one beat built from pairs 0 to 2, and pair 3 is discarded.
- R8: For a non-zero enable, in_ready is high only in a cycle where out_valid and out_ready are both high on the last beat of the current word.
- R9: out_valid is high only while in_valid is high and the enable is non-zero. While out_ready is low and the input is held, out_data stays unchanged and no beat is skipped.
- R10: With chan_en all zero, out_valid stays low and in_ready is high, so input words are discarded.
- R11: Reset returns the beat counter to the first beat. The first beat presented after reset is beat 0 of the word on the input, even if a reset interrupted that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | NCH (2 or 4) | Channel-enable bitmap, bit 0 = A |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word consumed |
| in_data | input | IN_W (128) | Packed payload word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | NCH*32 | Per-channel output lanes |

## Verification
The bench builds two instances side by side. One uses FOUR_CH=0, with a 2-bit enable and a 64-bit output. The other uses FOUR_CH=1, with a 4-bit enable and a 128-bit output. Between them they cover every beat count the block can produce: four, two and one beat per word. They also cover the three-channel case that discards a pair and the sparse enable sets (B only, C only, D only, B+D), where the lane rank differs from the channel index. Directed runs add back-pressure in the middle of a word, a reset in the middle of a word, and the all-disabled enable.

// File: rtl/iqu_pkg.sv
package iqu_pkg;

  localparam int SAMPLE_W_DFLT = 16;

  // Number of set bits in a small enable vector.
  function automatic int unsigned ones_in(input logic [3:0] v, input int unsigned n);
    int unsigned s;
    s = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < n) s += int'(v[i]);
    end
    return s;
  endfunction

  // Output beats needed to drain one word of `pairs` pairs for k channels.
  function automatic int unsigned beats_per_word(input int unsigned pairs,
                                                 input int unsigned k);
    if (k == 0) return 1;
    else if (pairs < k) return 1;
    else return pairs / k;
  endfunction

endpackage

// File: rtl/iqu_enable_decode.sv
module iqu_enable_decode #(
  parameter int NCH      = 2,
  parameter int IN_PAIRS = 4,
  localparam int CW      = $clog2(NCH + 1),
  localparam int BW      = (IN_PAIRS > 1) ? $clog2(IN_PAIRS) : 1
) (
  input  logic [NCH-1:0] chan_en,
  output logic [CW-1:0]  en_cnt,
  output logic [BW-1:0]  beat_max,
  output logic           any_en
);
  import iqu_pkg::*;

  logic [3:0]  en_wide;
  int unsigned k;

  always_comb begin
    en_wide = '0;
    en_wide[NCH-1:0] = chan_en;
  end

  always_comb begin
    k        = ones_in(en_wide, NCH);
    en_cnt   = CW'(k);
    any_en   = (k != 0);
    beat_max = BW'(beats_per_word(IN_PAIRS, k) - 1);
  end

endmodule

// File: rtl/iqu_beat_ctrl.sv
module iqu_beat_ctrl #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [BW-1:0] beat_max,
  output logic [BW-1:0] beat,
  output logic          last
);

  // A changed enable can leave beat above beat_max; >= still closes the word.
  assign last = (beat >= beat_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (advance) begin
      beat <= last ? '0 : beat + 1'b1;
    end
  end

endmodule

// File: rtl/iqu_lane_map.sv
module iqu_lane_map #(
  parameter int NCH      = 2,
  parameter int IN_PAIRS = 4,
  parameter int PAIR_W   = 32,
  localparam int CW      = $clog2(NCH + 1),
  localparam int BW      = (IN_PAIRS > 1) ? $clog2(IN_PAIRS) : 1,
  localparam int IN_W    = IN_PAIRS * PAIR_W,
  localparam int OUT_W   = NCH * PAIR_W
) (
  input  logic [IN_W-1:0]  in_word,
  input  logic [NCH-1:0]   chan_en,
  input  logic [CW-1:0]    en_cnt,
  input  logic [BW-1:0]    beat,
  output logic [OUT_W-1:0] out_word
);

  logic [PAIR_W-1:0] pairs [IN_PAIRS];

  for (genvar p = 0; p < IN_PAIRS; p++) begin : g_pair
    assign pairs[p] = in_word[p*PAIR_W +: PAIR_W];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    int                rank;
    int                idx;
    logic [BW-1:0]     pick;
    logic [PAIR_W-1:0] lane;

    always_comb begin
      rank = 0;
      for (int j = 0; j < c; j++) rank += int'(chan_en[j]);
      idx  = int'(beat) * int'(en_cnt) + rank;
      pick = BW'(idx);
      lane = (chan_en[c] && (idx < IN_PAIRS)) ? pairs[pick] : '0;
    end

    assign out_word[c*PAIR_W +: PAIR_W] = lane;
  end

endmodule

// File: rtl/iq_lane_unpacker.sv
module iq_lane_unpacker #(
  parameter bit  FOUR_CH  = 1'b0,
  parameter int  SAMPLE_W = iqu_pkg::SAMPLE_W_DFLT,
  parameter int  IN_W     = 128,
  localparam int NCH      = FOUR_CH ? 4 : 2,
  localparam int PAIR_W   = 2 * SAMPLE_W,
  localparam int IN_PAIRS = IN_W / PAIR_W,
  localparam int OUT_W    = NCH * PAIR_W,
  localparam int CW       = $clog2(NCH + 1),
  localparam int BW       = (IN_PAIRS > 1) ? $clog2(IN_PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   chan_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  logic [CW-1:0] en_cnt;
  logic [BW-1:0] beat_max;
  logic [BW-1:0] beat;
  logic          any_en;
  logic          last;
  logic          advance;

  iqu_enable_decode #(.NCH(NCH), .IN_PAIRS(IN_PAIRS)) u_decode (
    .chan_en  (chan_en),
    .en_cnt   (en_cnt),
    .beat_max (beat_max),
    .any_en   (any_en)
  );

  assign out_valid = in_valid && any_en;
  assign advance   = out_valid && out_ready;
  assign in_ready  = any_en ? (advance && last) : 1'b1;

  iqu_beat_ctrl #(.BW(BW)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .beat_max (beat_max),
    .beat     (beat),
    .last     (last)
  );

  iqu_lane_map #(.NCH(NCH), .IN_PAIRS(IN_PAIRS), .PAIR_W(PAIR_W)) u_map (
    .in_word  (in_data),
    .chan_en  (chan_en),
    .en_cnt   (en_cnt),
    .beat     (beat),
    .out_word (out_data)
  );

endmodule

// File: rtl/iqu_checker.sv
module iqu_checker #(
  parameter int NCH      = 2,
  parameter int PAIR_W   = 32,
  parameter int IN_PAIRS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            chan_en,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [IN_PAIRS*PAIR_W-1:0] in_data,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [NCH*PAIR_W-1:0]     out_data
);

  // R8
  ready_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && (chan_en != '0)) |-> (out_valid && out_ready));

  // R10
  idle_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en == '0) |-> (!out_valid && in_ready));

  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!(in_valid && $stable(chan_en) && $stable(in_data)) || $stable(out_data)));

  // R6
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (2 * $countones(chan_en) > IN_PAIRS)) |-> in_ready);

  for (genvar c = 0; c < NCH; c++) begin : g_zero
    // R3
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !chan_en[c]) |-> (out_data[c*PAIR_W +: PAIR_W] == '0));
  end

endmodule

bind iq_lane_unpacker iqu_checker #(
  .NCH(NCH), .PAIR_W(PAIR_W), .IN_PAIRS(IN_PAIRS)
) u_iqu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_iq_lane_unpacker.sv
module test_iq_lane_unpacker;

  localparam logic [127:0] W0 = 128'h4443_4241_3433_3231_2423_2221_1413_1211;
  localparam logic [127:0] W1 = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98;
  localparam logic [127:0] W2 = 128'hFFFF_0000_8001_7FFE_5555_AAAA_0F0F_F0F0;

  typedef struct packed {
    logic         four;
    logic [3:0]   en;
    logic [127:0] w;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h1, W0}, '{1'b0, 4'h2, W1}, '{1'b0, 4'h3, W0}, '{1'b0, 4'h3, W2},
    '{1'b1, 4'h1, W1}, '{1'b1, 4'h4, W0}, '{1'b1, 4'h5, W2}, '{1'b1, 4'hA, W0},
    '{1'b1, 4'hF, W0}, '{1'b1, 4'hF, W1}, '{1'b1, 4'h7, W2}, '{1'b1, 4'hD, W0},
    '{1'b1, 4'h8, W2}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] in_data;
  logic         in_valid;
  logic         out_ready;
  logic         sel4;
  logic [3:0]   en;

  logic         vld2, rdy2, ov2;
  logic [63:0]  dat2;
  logic         vld4, rdy4, ov4;
  logic [127:0] dat4;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign vld2 = in_valid && !sel4;
  assign vld4 = in_valid && sel4;

  iq_lane_unpacker #(.FOUR_CH(1'b0)) i_iq_lane_unpacker (
    .clk(clk), .rst_n(rst_n), .chan_en(en[1:0]), .in_valid(vld2), .in_ready(rdy2),
    .in_data(in_data), .out_valid(ov2), .out_ready(out_ready), .out_data(dat2)
  );

  iq_lane_unpacker #(.FOUR_CH(1'b1)) i_iq_lane_unpacker_quad (
    .clk(clk), .rst_n(rst_n), .chan_en(en), .in_valid(vld4), .in_ready(rdy4),
    .in_data(in_data), .out_valid(ov4), .out_ready(out_ready), .out_data(dat4)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int n_en(input bit four, input logic [3:0] e);
    int k = 0;
    for (int c = 0; c < (four ? 4 : 2); c++) if (e[c]) k++;
    return k;
  endfunction

  function automatic int exp_beats(input bit four, input logic [3:0] e);
    int k = n_en(four, e);
    return (k == 0) ? 0 : ((k > 2) ? 1 : 4 / k);
  endfunction

  // Model: list enabled channels in letter order, hand them consecutive pairs.
  function automatic logic [127:0] exp_word(input bit four, input logic [3:0] e,
                                            input logic [127:0] w, input int beat);
    int list [4];
    int k = 0;
    logic [127:0] r = '0;
    for (int c = 0; c < (four ? 4 : 2); c++) begin
      if (e[c]) begin list[k] = c; k++; end
    end
    for (int j = 0; j < k; j++) begin
      int p = beat * k + j;
      if (p < 4) r[list[j]*32 +: 32] = w[p*32 +: 32];
    end
    return r;
  endfunction

  function automatic logic [127:0] act_data(input bit four);
    return four ? dat4 : {64'b0, dat2};
  endfunction

  function automatic string beat_req(input bit four, input logic [3:0] e);
    int k = n_en(four, e);
    if (k == 1) return "R4";
    if (k == 2) return "R5";
    if (k == 3) return "R7";
    return "R6";
  endfunction

  task automatic run_word(input bit four, input logic [3:0] e, input logic [127:0] w);
    int nb = exp_beats(four, e);
    @(negedge clk);
    sel4 = four; en = e; in_data = w; in_valid = 1'b1; out_ready = 1'b1;
    if (nb == 0) begin
      #2;
      chk(!(four ? ov4 : ov2), "R10 out_valid", 128'(four ? ov4 : ov2), 128'd0);
      chk((four ? rdy4 : rdy2), "R10 in_ready", 128'(four ? rdy4 : rdy2), 128'd1);
      @(negedge clk);
    end else begin
      for (int b = 0; b < nb; b++) begin
        logic [127:0] ex;
        logic         r;
        #2;
        ex = exp_word(four, e, w, b);
        r  = four ? rdy4 : rdy2;
        chk((four ? ov4 : ov2), "R9 out_valid", 128'(four ? ov4 : ov2), 128'd1);
        chk(act_data(four) === ex, "R1 R2 R3 lanes", act_data(four), ex);
        chk(r == (b == nb - 1), {beat_req(four, e), " R8 in_ready per beat"},
            128'(r), 128'(b == nb - 1));
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=timeout exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; sel4 = 1'b0; en = 4'h3;
    in_data = '0;
    repeat (3) @(negedge clk);
    #2;
    // R11 reset state: no beat offered, no word consumed
    chk(!ov2 && !ov4, "R11 reset out_valid", 128'({ov2, ov4}), 128'd0);
    chk(!rdy2 && !rdy4, "R11 reset in_ready", 128'({rdy2, rdy4}), 128'd0);
    // R1 output widths per mode
    chk($bits(dat2) == 64, "R1 width two-channel", 128'($bits(dat2)), 128'd64);
    chk($bits(dat4) == 128, "R1 width four-channel", 128'($bits(dat4)), 128'd128);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) run_word(VECS[v].four, VECS[v].en, VECS[v].w);

    // R10: all channels disabled in both modes
    run_word(1'b0, 4'h0, W1);
    run_word(1'b1, 4'h0, W2);

    // R8: idle input, ready stays low
    @(negedge clk);
    sel4 = 1'b0; en = 4'h3; in_valid = 1'b0; out_ready = 1'b1;
    #2;
    chk(!rdy2, "R8 idle in_ready", 128'(rdy2), 128'd0);

    // R9: back-pressure in four-channel mode, A+C
    @(negedge clk);
    sel4 = 1'b1; en = 4'h5; in_data = W2; in_valid = 1'b1; out_ready = 1'b0;
    for (int s = 0; s < 3; s++) begin
      #2;
      chk(ov4 && !rdy4, "R9 stall valid/ready", 128'({ov4, rdy4}), 128'b10);
      chk(dat4 === exp_word(1'b1, 4'h5, W2, 0), "R9 stall data", dat4,
          exp_word(1'b1, 4'h5, W2, 0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #2;
    chk(dat4 === exp_word(1'b1, 4'h5, W2, 0) && !rdy4, "R9 release beat0", dat4,
        exp_word(1'b1, 4'h5, W2, 0));
    @(negedge clk);
    #2;
    chk(dat4 === exp_word(1'b1, 4'h5, W2, 1) && rdy4, "R9 release beat1", dat4,
        exp_word(1'b1, 4'h5, W2, 1));
    @(negedge clk);
    in_valid = 1'b0;

    // R11: reset in the middle of a single-channel word
    @(negedge clk);
    sel4 = 1'b0; en = 4'h1; in_data = W0; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #2;
    chk({64'b0, dat2} === exp_word(1'b0, 4'h1, W0, 2), "R4 beat2 before reset",
        {64'b0, dat2}, exp_word(1'b0, 4'h1, W0, 2));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk({64'b0, dat2} === exp_word(1'b0, 4'h1, W0, 0), "R11 restart at beat0",
        {64'b0, dat2}, exp_word(1'b0, 4'h1, W0, 0));
    @(negedge clk);
    in_valid = 1'b0;

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule